// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a computer-operating-properly watchdog. A free-running prescaler divides the bus clock by 2^PRE_EXP, where PRE_EXP defaults to 15. A second counter then counts the prescaler periods against a limit of 1, 4, 16 or 64, chosen by a 2-bit rate code. If software does not service the watchdog before that limit is passed, the block raises a reset request for one clock.

Servicing takes two writes in order to an 8-bit service port. Writing 0x55 arms the clear. A later 0xAA, written while armed, zeroes the timeout count and disarms the block. The prescaler is never cleared by a service, so the time to the next request lies between L and L+1 prescaler periods. With a 2 MHz bus clock the four settings give roughly 16.4 ms, 65.5 ms, 262 ms and 1.05 s.

The enable input stops the watchdog entirely while it is low. The rate code is taken only while the block is in reset or disabled.

Top module: `cop_watchdog`

## Requirements
- R1: After reset, reset_req is 0 and the block is not armed, so a lone 0xAA written soon after reset does not delay the first request.
- R2: With no service, the first reset_req comes (L+1)·2^PRE_EXP clock edges after enable rises, where L = 1, 4, 16, 64 for rate codes 0, 1, 2, 3.
- R3: reset_req is high for exactly one clock, and counting then restarts at zero, so the next request follows (L+1)·2^PRE_EXP edges later.
- R4: A 0x55 write followed later by a 0xAA write clears the timeout count without touching the prescaler. The edges are counted from the first enabled edge after enable rises, starting at 1. For a clear taken at edge e, the next request is due at edge (floor(e/2^PRE_EXP)+L+1)·2^PRE_EXP.
- R5: A 0xAA write while not armed has no effect.
- R6: While armed, a repeated 0x55 write or a write of any other value keeps the block armed.
- R7: A request clears the armed state, so a 0xAA after a request without a fresh 0x55 has no effect.
- R8: A clear that lands on the same edge as an expiry suppresses that request.
- R9: rate_sel is sampled only in reset or while enable is low; changes while running are ignored.
- R10: While enable is low, the counters are held at zero, reset_req stays 0, the armed state is cleared and service writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the watchdog when high |
| svc_wr | input | 1 | Service register write strobe |
| svc_data | input | 8 | Service write data (0x55 arm, 0xAA clear) |
| rate_sel | input | 2 | Timeout rate code |
| reset_req | output | 1 | One-cycle reset request |

## Verification
The request is registered, so it goes high in the cycle after the edge where the final prescaler period ends. A service write is acted on at the edge that captures it. The bench keeps its own count of clock edges since enable rose, drives inputs on falling edges and also samples on falling edges. It then compares the edge number at which reset_req appears against the arithmetic formulas in R2 to R4. It sweeps all four rate codes with PRE_EXP = 4, and places service writes at chosen edges so that a wrong arm or clear decision moves the request to a different edge number.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam logic [7:0] SVC_ARM_KEY  = 8'h55;
    localparam logic [7:0] SVC_FIRE_KEY = 8'hAA;

    typedef enum logic [1:0] {
        KEY_IDLE,
        KEY_ARM,
        KEY_FIRE,
        KEY_JUNK
    } key_e;

    function automatic key_e decode_key(input logic wr, input logic [7:0] data);
        if (!wr)                       return KEY_IDLE;
        else if (data == SVC_ARM_KEY)  return KEY_ARM;
        else if (data == SVC_FIRE_KEY) return KEY_FIRE;
        else                           return KEY_JUNK;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_EXP = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    logic [PRE_EXP-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign tick = run && (&cnt);

    // R4: the prescaler wraps after each period and is cleared only by disable/reset
    a_r4_prescaler_wraps: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt == '0));
endmodule

// File: rtl/wdt_service_key.sv
module wdt_service_key
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       wr,
    input  logic [7:0] data,
    input  logic       expire,
    output logic       armed,
    output logic       fire
);
    key_e kind;

    assign kind = decode_key(wr, data);
    assign fire = run && armed && (kind == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst || !run)          armed <= 1'b0;
        else if (expire)          armed <= 1'b0;
        else if (fire)            armed <= 1'b0;
        else if (kind == KEY_ARM) armed <= 1'b1;
    end

    // R6: arming only ever follows a 0x55 write
    a_r6_arm_source: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(wr && data == SVC_ARM_KEY));
    // R4: a completed clear leaves the block disarmed
    a_r4_fire_disarms: assert property (@(posedge clk) disable iff (rst)
        fire |=> !armed);
    // R7: an expiry leaves the block disarmed
    a_r7_expire_disarms: assert property (@(posedge clk) disable iff (rst)
        expire |=> !armed);
endmodule

// File: rtl/wdt_timeout_div.sv
module wdt_timeout_div #(
    parameter int RATE_W   = 2,
    parameter int DIV_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              clear,
    input  logic [RATE_W-1:0] rate_in,
    output logic              expire,
    output logic              req
);
    localparam int CODES = 1 << RATE_W;
    localparam int DW    = DIV_STEP * (CODES - 1) + 1;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic [DW-1:0]     count;
    } div_state_t;

    div_state_t st;
    logic [DW-1:0] limit;

    always_comb begin
        limit = '0;
        for (int c = 0; c < CODES; c++) begin
            if (st.rate == RATE_W'(c)) limit = DW'(1) << (DIV_STEP * c);
        end
    end

    assign expire = tick && (st.count == limit) && !clear;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st.rate  <= rate_in;
            st.count <= '0;
            req      <= 1'b0;
        end else begin
            req <= expire;
            if (clear || expire) st.count <= '0;
            else if (tick)       st.count <= st.count + 1'b1;
        end
    end

    // R3: request is a single-cycle pulse
    a_r3_req_single: assert property (@(posedge clk) disable iff (rst)
        req |=> !req);
    // R10: no request while disabled
    a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        !run |=> !req);
    // R9: rate stays fixed while running
    a_r9_rate_frozen: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run)) |-> $stable(st.rate));
    // R2: count never passes the selected limit
    a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
        st.count <= limit);
endmodule

// File: rtl/cop_watchdog.sv
module cop_watchdog #(
    parameter int PRE_EXP  = 15,
    parameter int RATE_W   = 2,
    parameter int DIV_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              svc_wr,
    input  logic [7:0]        svc_data,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              reset_req
);
    logic tick, fire, expire, armed;

    wdt_prescaler #(.PRE_EXP(PRE_EXP)) u_pre (
        .clk(clk), .rst(rst), .run(enable), .tick(tick)
    );

    wdt_service_key u_key (
        .clk(clk), .rst(rst), .run(enable), .wr(svc_wr), .data(svc_data),
        .expire(expire), .armed(armed), .fire(fire)
    );

    wdt_timeout_div #(.RATE_W(RATE_W), .DIV_STEP(DIV_STEP)) u_div (
        .clk(clk), .rst(rst), .run(enable), .tick(tick), .clear(fire),
        .rate_in(rate_sel), .expire(expire), .req(reset_req)
    );

    // R8: a clear on the expiry edge means no request follows
    a_r8_fire_blocks_req: assert property (@(posedge clk) disable iff (rst)
        fire |=> !reset_req);
    // R1: no request in the cycle after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !reset_req);
endmodule

// File: tb/tb_cop_watchdog.sv
module tb_cop_watchdog;
    localparam int PE = 4;
    localparam int PP = 1 << PE;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       svc_wr = 1'b0;
    logic [7:0] svc_data = 8'h00;
    logic [1:0] rate_sel = 2'd0;
    logic       reset_req;

    int checks = 0;
    int fails = 0;
    int edge_no = 0;
    int at;
    bit done = 0;

    always #4 clk = ~clk;

    always @(posedge clk) edge_no <= (enable && !rst) ? edge_no + 1 : 0;

    cop_watchdog #(.PRE_EXP(PE)) dut (
        .clk(clk), .rst(rst), .enable(enable), .svc_wr(svc_wr),
        .svc_data(svc_data), .rate_sel(rate_sel), .reset_req(reset_req)
    );

    function automatic int lim(int r);
        return 1 << (2 * r);
    endfunction

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic restart(input int r);
        @(negedge clk);
        enable = 1'b0;
        rate_sel = 2'(r);
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic write_at(input int e, input logic [7:0] d);
        while (edge_no != e - 1) @(negedge clk);
        svc_wr = 1'b1;
        svc_data = d;
        @(negedge clk);
        svc_wr = 1'b0;
        svc_data = 8'h00;
    endtask

    task automatic wait_req(output int where);
        where = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (reset_req) begin
                where = edge_no;
                break;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(reset_req == 1'b0, "R1 reset quiet", reset_req, 0);
        rst = 1'b0;
        // R1: not armed after reset, lone 0xAA has no effect
        restart(1);
        write_at(40, 8'hAA);
        wait_req(at);
        check(at == 80, "R1 unarmed after reset", at, 80);

        // R2/R3 sweep over all rate codes
        for (int r = 0; r < 4; r++) begin
            restart(r);
            wait_req(at);
            check(at == (lim(r) + 1) * PP, "R2 timeout", at, (lim(r) + 1) * PP);
            @(negedge clk);
            check(reset_req == 1'b0, "R3 single cycle", reset_req, 0);
            wait_req(at);
            check(at == 2 * (lim(r) + 1) * PP, "R3 restart period", at, 2 * (lim(r) + 1) * PP);
        end

        // R4 arm then clear
        restart(1);
        write_at(30, 8'h55);
        write_at(40, 8'hAA);
        wait_req(at);
        check(at == (40 / PP + 5) * PP, "R4 clear", at, (40 / PP + 5) * PP);

        // R5 clear without arm
        restart(1);
        write_at(40, 8'hAA);
        wait_req(at);
        check(at == 80, "R5 unarmed clear", at, 80);

        // R6 other value keeps arm
        restart(1);
        write_at(20, 8'h55);
        write_at(30, 8'h12);
        write_at(40, 8'hAA);
        wait_req(at);
        check(at == 112, "R6 junk keeps arm", at, 112);

        // R6 repeated arm
        restart(1);
        write_at(20, 8'h55);
        write_at(30, 8'h55);
        write_at(40, 8'hAA);
        wait_req(at);
        check(at == 112, "R6 rearm keeps arm", at, 112);

        // R7 expiry disarms
        restart(1);
        write_at(20, 8'h55);
        wait_req(at);
        check(at == 80, "R7 first expiry", at, 80);
        write_at(100, 8'hAA);
        wait_req(at);
        check(at == 160, "R7 expiry disarms", at, 160);

        // R8 clear on the expiry edge
        restart(0);
        write_at(20, 8'h55);
        write_at(32, 8'hAA);
        wait_req(at);
        check(at == 64, "R8 clear beats expiry", at, 64);

        // R9 rate change while running ignored
        restart(0);
        @(negedge clk);
        rate_sel = 2'd3;
        wait_req(at);
        check(at == 32, "R9 rate frozen", at, 32);
        restart(3);
        wait_req(at);
        check(at == 65 * PP, "R9 rate taken when disabled", at, 65 * PP);

        // R10 disable holds everything
        restart(0);
        while (edge_no != 20) @(negedge clk);
        enable = 1'b0;
        svc_wr = 1'b1;
        svc_data = 8'h55;
        @(negedge clk);
        svc_wr = 1'b0;
        svc_data = 8'h00;
        begin
            int seen = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (reset_req) seen++;
            end
            check(seen == 0, "R10 no request when disabled", seen, 0);
        end
        enable = 1'b1;
        write_at(20, 8'hAA);
        wait_req(at);
        check(at == 32, "R10 counters zeroed and write ignored", at, 32);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule